// File: doc/BRIEF.md
# Cartridge Bank Mapper with Clock Register Window

This block sits between a CPU bus and the storage of a plug-in cartridge. It translates CPU addresses into ROM and RAM addresses, holds the switchable ROM bank, and holds an 8-bit window selector. The selector decides what appears in the external window at 0xA000-0xBFFF. Values 0 to 7 show one of eight 8 KiB RAM banks. Values 0x08 to 0x0C show one of five registers of a separate real-time-clock block. Every other value shows nothing.

One enable flag guards both RAM and clock accesses. Toward the clock the block offers a side port: a register index, read data coming back, a one-cycle write strobe with data, and a one-cycle latch strobe with data. A static input tells the block whether a clock is fitted at all. CPU writes are single-cycle strobes that update the registers on the next rising clock edge. Reads are combinational from the current address.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the selector is 0 and the enable is clear. A read at 0x4000 therefore drives romAddr = 0x04000, and a window read returns 0xFF.
- R2: A write in 0x2000-0x3FFF loads the ROM bank from data[6:0], and a value of 0 is stored as 1. Reads in 0x0000-0x3FFF drive romAddr = address[13:0]. Reads in 0x4000-0x7FFF drive romAddr = bank*0x4000 + address[13:0]. In both cases cpuRdData returns romRdData.
- R3: A write in 0x0000-0x1FFF sets the enable when data[3:0] = 0xA and clears it for any other low nibble. The upper nibble is not examined.
- R4: A write in 0x4000-0x5FFF stores all eight data bits as the selector. With the selector at 0-7 and the enable set, a window access drives ramAddr = selector*0x2000 + address[12:0]. A read returns ramRdData. A write pulses ramWrEn with ramWrData = data in the same cycle as cpuWr.
- R5: With the selector at 0-7 and the enable clear, window reads return 0xFF and window writes raise no ramWrEn.
- R6: With the selector at 0x08-0x0C, the enable set and rtcPresent high, rtcIndex = selector - 8 and a window read returns rtcRdData.
- R7: Under the conditions of R6, a window write raises rtcWrStrobe for exactly the cycle in which cpuWr is high, with rtcWrData = data and rtcIndex = selector - 8.
- R8: With the selector at 0x08-0x0C and either the enable clear or rtcPresent low, window reads return 0xFF and window writes raise no rtcWrStrobe.
- R9: A write in 0x6000-0x7FFF raises rtcLatchStrobe in the same cycle, with rtcLatchData = data, only when rtcPresent is high. It changes no bank register.
- R10: A selector value above 0x0C, for example 0x0D, 0x88 or 0xFF, makes window reads return 0xFF and window writes raise no strobe.
- R11: Accesses in 0x8000-0x9FFF and 0xC000-0xFFFF read 0xFF, raise no strobe and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, one cycle per write |
| cpuRdData | output | 8 | Read data for the current address |
| romAddr | output | 21 | Mapped ROM byte address |
| romRdData | input | 8 | ROM data at romAddr |
| ramAddr | output | 16 | Mapped RAM byte address |
| ramWrEn | output | 1 | RAM write pulse |
| ramWrData | output | 8 | RAM write data |
| ramRdData | input | 8 | RAM data at ramAddr |
| rtcPresent | input | 1 | A clock block is fitted |
| rtcIndex | output | 3 | Clock register index |
| rtcRdData | input | 8 | Clock register read data |
| rtcWrStrobe | output | 1 | Clock register write pulse |
| rtcWrData | output | 8 | Clock register write data |
| rtcLatchStrobe | output | 1 | Clock latch pulse |
| rtcLatchData | output | 8 | Byte passed with the latch pulse |

## Verification
A selector or enable update and the window access that follows it meet at a single clock edge. The register takes its new value on that edge, and the window decode of the next access has to use that new value. The bench provokes this by issuing write-then-access pairs back to back: selector moves from a RAM bank to a clock register, enable clears followed at once by a clock write, and selector moves to an unmapped value followed by a read. It judges each access in the cycle after the edge against a model that applies the update first. A second overlap is a clock write strobe during the very cycle the CPU write is presented. Here the bench samples the strobe, the index and the data before the edge, and updates its clock-register model only from what that cycle should have produced.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

  typedef enum logic [2:0] {
    RG_ENABLE  = 3'd0,
    RG_ROMBANK = 3'd1,
    RG_SELECT  = 3'd2,
    RG_LATCH   = 3'd3,
    RG_VRAM    = 3'd4,
    RG_WINDOW  = 3'd5,
    RG_WRAM    = 3'd6,
    RG_HIGH    = 3'd7
  } busRegion_e;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic inRom;
    logic inWindow;
    logic winWr;
    logic romBankWe;
    logic selWe;
    logic enWe;
    logic latchFire;
  } mapCtrl_t;

endpackage

// File: rtl/cart_mapper_ctrl.sv
module cart_mapper_ctrl
  import cart_mapper_pkg::*;
(
  input  logic [2:0] region,
  input  logic       cpuWr,
  input  logic       rtcPresent,
  output mapCtrl_t   ctrl
);

  busRegion_e rg;

  always_comb begin
    rg = busRegion_e'(region);
    ctrl = '0;
    // lower half of the map is always ROM on reads
    ctrl.inRom    = ~region[2];
    ctrl.inWindow = (rg == RG_WINDOW);
    ctrl.winWr    = cpuWr && (rg == RG_WINDOW);
    ctrl.enWe     = cpuWr && (rg == RG_ENABLE);
    ctrl.romBankWe = cpuWr && (rg == RG_ROMBANK);
    ctrl.selWe    = cpuWr && (rg == RG_SELECT);
    ctrl.latchFire = cpuWr && (rg == RG_LATCH) && rtcPresent;
  end

endmodule

// File: rtl/cart_mapper_dp.sv
module cart_mapper_dp
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANK_W     = 7,
  parameter int RAM_BANK_COUNT = 8,
  parameter int CLK_REG_COUNT  = 5,
  parameter int DATA_W         = 8,
  parameter int BANK_OFS_W     = 14,
  parameter int WIN_OFS_W      = 13
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  mapCtrl_t                          ctrl,
  input  logic [BANK_OFS_W:0]               addrLow,
  input  logic [DATA_W-1:0]                 cpuWrData,
  input  logic                              rtcPresent,
  input  logic [DATA_W-1:0]                 romRdData,
  input  logic [DATA_W-1:0]                 ramRdData,
  input  logic [DATA_W-1:0]                 rtcRdData,
  output logic [DATA_W-1:0]                 cpuRdData,
  output logic [ROM_BANK_W+BANK_OFS_W-1:0]  romAddr,
  output logic [$clog2(RAM_BANK_COUNT)+WIN_OFS_W-1:0] ramAddr,
  output logic                              ramWrEn,
  output logic [DATA_W-1:0]                 ramWrData,
  output logic [$clog2(CLK_REG_COUNT)-1:0]  rtcIndex,
  output logic                              rtcWrStrobe,
  output logic [DATA_W-1:0]                 rtcWrData,
  output logic                              rtcLatchStrobe,
  output logic [DATA_W-1:0]                 rtcLatchData
);

  localparam int RAM_BANK_W   = $clog2(RAM_BANK_COUNT);
  localparam int CLK_IDX_W    = $clog2(CLK_REG_COUNT);
  localparam int CLK_SEL_BASE = RAM_BANK_COUNT;
  localparam int CLK_SEL_END  = CLK_SEL_BASE + CLK_REG_COUNT;
  localparam logic [DATA_W-1:0] EMPTY_BYTE = '1;

  logic [ROM_BANK_W-1:0] romBankQ;
  logic [DATA_W-1:0]     selQ;
  logic                  enQ;

  logic [ROM_BANK_W-1:0] newBank;
  logic                  selIsRam;
  logic                  selIsClk;
  logic                  ramOk;
  logic                  clkOk;

  // bank 0 cannot be placed in the switchable half
  always_comb begin
    newBank = cpuWrData[ROM_BANK_W-1:0];
    if (newBank == '0) newBank = ROM_BANK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBankQ <= ROM_BANK_W'(1);
      selQ     <= '0;
      enQ      <= 1'b0;
    end else begin
      if (ctrl.romBankWe) romBankQ <= newBank;
      if (ctrl.selWe)     selQ     <= cpuWrData;
      if (ctrl.enWe)      enQ      <= (cpuWrData[3:0] == 4'hA);
    end
  end

  // selector decode: RAM banks first, clock registers directly above
  always_comb begin
    selIsRam = (selQ < DATA_W'(RAM_BANK_COUNT));
    selIsClk = (selQ >= DATA_W'(CLK_SEL_BASE)) && (selQ < DATA_W'(CLK_SEL_END));
    ramOk    = selIsRam && enQ;
    clkOk    = selIsClk && enQ && rtcPresent;
  end

  always_comb begin
    if (addrLow[BANK_OFS_W])
      romAddr = {romBankQ, addrLow[BANK_OFS_W-1:0]};
    else
      romAddr = {{ROM_BANK_W{1'b0}}, addrLow[BANK_OFS_W-1:0]};
    ramAddr  = {selQ[RAM_BANK_W-1:0], addrLow[WIN_OFS_W-1:0]};
    rtcIndex = CLK_IDX_W'(selQ - DATA_W'(CLK_SEL_BASE));
  end

  always_comb begin
    ramWrEn        = ctrl.winWr && ramOk;
    ramWrData      = cpuWrData;
    rtcWrStrobe    = ctrl.winWr && clkOk;
    rtcWrData      = cpuWrData;
    rtcLatchStrobe = ctrl.latchFire;
    rtcLatchData   = cpuWrData;
  end

  always_comb begin
    cpuRdData = EMPTY_BYTE;
    if (ctrl.inRom)
      cpuRdData = romRdData;
    else if (ctrl.inWindow) begin
      if (ramOk)      cpuRdData = ramRdData;
      else if (clkOk) cpuRdData = rtcRdData;
    end
  end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANK_W     = 7,
  parameter int RAM_BANK_COUNT = 8,
  parameter int CLK_REG_COUNT  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWr,
  output logic [7:0]  cpuRdData,
  output logic [ROM_BANK_W+13:0] romAddr,
  input  logic [7:0]  romRdData,
  output logic [$clog2(RAM_BANK_COUNT)+12:0] ramAddr,
  output logic        ramWrEn,
  output logic [7:0]  ramWrData,
  input  logic [7:0]  ramRdData,
  input  logic        rtcPresent,
  output logic [$clog2(CLK_REG_COUNT)-1:0] rtcIndex,
  input  logic [7:0]  rtcRdData,
  output logic        rtcWrStrobe,
  output logic [7:0]  rtcWrData,
  output logic        rtcLatchStrobe,
  output logic [7:0]  rtcLatchData
);

  localparam int DATA_W     = 8;
  localparam int BANK_OFS_W = 14;
  localparam int WIN_OFS_W  = 13;
  localparam int ROM_ADDR_W = ROM_BANK_W + BANK_OFS_W;

  mapCtrl_t ctrl;

  cart_mapper_ctrl u_ctrl (
    .region     (cpuAddr[15:13]),
    .cpuWr      (cpuWr),
    .rtcPresent (rtcPresent),
    .ctrl       (ctrl)
  );

  cart_mapper_dp #(
    .ROM_BANK_W     (ROM_BANK_W),
    .RAM_BANK_COUNT (RAM_BANK_COUNT),
    .CLK_REG_COUNT  (CLK_REG_COUNT),
    .DATA_W         (DATA_W),
    .BANK_OFS_W     (BANK_OFS_W),
    .WIN_OFS_W      (WIN_OFS_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .addrLow        (cpuAddr[BANK_OFS_W:0]),
    .cpuWrData      (cpuWrData),
    .rtcPresent     (rtcPresent),
    .romRdData      (romRdData),
    .ramRdData      (ramRdData),
    .rtcRdData      (rtcRdData),
    .cpuRdData      (cpuRdData),
    .romAddr        (romAddr),
    .ramAddr        (ramAddr),
    .ramWrEn        (ramWrEn),
    .ramWrData      (ramWrData),
    .rtcIndex       (rtcIndex),
    .rtcWrStrobe    (rtcWrStrobe),
    .rtcWrData      (rtcWrData),
    .rtcLatchStrobe (rtcLatchStrobe),
    .rtcLatchData   (rtcLatchData)
  );

endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker #(
  parameter int BANK_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        region,
  input logic              highHalf,
  input logic              cpuWr,
  input logic [3:0]        enNibble,
  input logic              rtcPresent,
  input logic [BANK_W-1:0] bankField,
  input logic              ramWrEn,
  input logic              rtcWrStrobe,
  input logic              rtcLatchStrobe
);

  // R2: the switchable ROM half never shows bank 0
  p_bank_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!region[2] && highHalf) |-> (bankField != '0));

  // R5: clearing the enable blocks window writes in the next cycle
  p_clear_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && region == 3'd0 && enNibble != 4'hA) |=> (!ramWrEn && !rtcWrStrobe));

  // R4: a RAM write pulse rides only on a CPU write into the window
  p_ram_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (cpuWr && region == 3'd5));

  // R4: at most one target is written per cycle
  p_single_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramWrEn, rtcWrStrobe, rtcLatchStrobe}));

  // R7: the clock write pulse is aligned to a CPU window write with a clock fitted
  p_clk_write_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    rtcWrStrobe |-> (cpuWr && region == 3'd5 && rtcPresent));

  // R9: latch fires exactly on a latch-region write with a clock fitted
  p_latch_fires_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && region == 3'd3 && rtcPresent) |-> rtcLatchStrobe);

  p_latch_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    rtcLatchStrobe |-> (cpuWr && region == 3'd3 && rtcPresent));

  // R11: regions outside ROM and window raise nothing
  p_outside_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (region == 3'd4 || region >= 3'd6) |-> (!ramWrEn && !rtcWrStrobe && !rtcLatchStrobe));

endmodule

bind cart_mapper cart_mapper_checker #(.BANK_W(ROM_BANK_W)) u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .region         (cpuAddr[15:13]),
  .highHalf       (cpuAddr[14]),
  .cpuWr          (cpuWr),
  .enNibble       (cpuWrData[3:0]),
  .rtcPresent     (rtcPresent),
  .bankField      (romAddr[ROM_ADDR_W-1:BANK_OFS_W]),
  .ramWrEn        (ramWrEn),
  .rtcWrStrobe    (rtcWrStrobe),
  .rtcLatchStrobe (rtcLatchStrobe)
);

// File: tb/cart_mapper_test.sv
module cart_mapper_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuRdData;
  logic [20:0] romAddr;
  logic [7:0]  romRdData;
  logic [15:0] ramAddr;
  logic        ramWrEn;
  logic [7:0]  ramWrData;
  logic [7:0]  ramRdData;
  logic        present = 1'b1;
  logic [2:0]  rtcIndex;
  logic [7:0]  rtcRdData;
  logic        rtcWrStrobe;
  logic [7:0]  rtcWrData;
  logic        rtcLatchStrobe;
  logic [7:0]  rtcLatchData;

  int unsigned nChecks = 0;
  int unsigned nFails = 0;

  // bench reference state
  logic [6:0] mBank;
  logic [7:0] mSel;
  logic       mEn;
  logic [7:0] rtcM [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] romByte(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ramByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign romRdData = romByte(romAddr);
  assign ramRdData = ramByte(ramAddr);
  assign rtcRdData = (rtcIndex < 3'd5) ? rtcM[rtcIndex] : 8'hEE;

  cart_mapper uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWr(cpuWr),
    .cpuRdData(cpuRdData), .romAddr(romAddr), .romRdData(romRdData),
    .ramAddr(ramAddr), .ramWrEn(ramWrEn), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .rtcPresent(present), .rtcIndex(rtcIndex), .rtcRdData(rtcRdData),
    .rtcWrStrobe(rtcWrStrobe), .rtcWrData(rtcWrData),
    .rtcLatchStrobe(rtcLatchStrobe), .rtcLatchData(rtcLatchData)
  );

  function automatic logic [20:0] expRomAddr(input logic [15:0] a);
    return a[14] ? {mBank, a[13:0]} : {7'd0, a[13:0]};
  endfunction

  function automatic logic selRam();
    return mSel < 8'd8;
  endfunction

  function automatic logic selClk();
    return (mSel >= 8'd8) && (mSel <= 8'h0C);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (!a[15]) return romByte(expRomAddr(a));
    if (a[15:13] != 3'd5) return 8'hFF;
    if (selRam() && mEn) return ramByte({mSel[2:0], a[12:0]});
    if (selClk() && mEn && present) return rtcM[mSel - 8'd8];
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic [15:0] a, input logic [7:0] d, input logic wr, input string force_tag);
    logic [2:0] rg;
    logic inWin, clkOk, eRam, eRtc, eLatch;
    string tag;
    rg = a[15:13];
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = wr;
    #1;
    inWin  = (rg == 3'd5);
    clkOk  = mEn && present;
    eRam   = wr && inWin && selRam() && mEn;
    eRtc   = wr && inWin && selClk() && clkOk;
    eLatch = wr && (rg == 3'd3) && present;
    if (force_tag != "") tag = force_tag;
    else if (inWin) tag = selRam() ? (mEn ? "R4" : "R5")
                        : selClk() ? (clkOk ? (wr ? "R7" : "R6") : "R8") : "R10";
    else if (rg == 3'd3 && wr) tag = "R9";
    else if (rg == 3'd0 && wr) tag = "R3";
    else if (rg == 3'd2 && wr) tag = "R4";
    else if (!a[15]) tag = "R2";
    else tag = "R11";
    chk(tag, "ramWrEn", ramWrEn, eRam);
    chk(tag, "rtcWrStrobe", rtcWrStrobe, eRtc);
    chk(tag, "rtcLatchStrobe", rtcLatchStrobe, eLatch);
    if (!wr) chk(tag, "cpuRdData", cpuRdData, expRead(a));
    if (!a[15]) chk(tag, "romAddr", romAddr, expRomAddr(a));
    if (eRam) begin
      chk(tag, "ramAddr", ramAddr, {mSel[2:0], a[12:0]});
      chk(tag, "ramWrData", ramWrData, d);
    end
    if (eRtc) begin
      chk(tag, "rtcIndex", rtcIndex, 3'(mSel - 8'd8));
      chk(tag, "rtcWrData", rtcWrData, d);
    end
    if (eLatch) chk(tag, "rtcLatchData", rtcLatchData, d);
    @(posedge clk);
    #1;
    cpuWr = 1'b0;
    if (wr) begin
      case (rg)
        3'd0: mEn = (d[3:0] == 4'hA);
        3'd1: mBank = (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
        3'd2: mSel = d;
        default: ;
      endcase
      if (eRtc) rtcM[mSel - 8'd8] = d;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    mBank = 7'd1; mSel = 8'd0; mEn = 1'b0;
    for (int i = 0; i < 5; i++) rtcM[i] = 8'(8'h10 + i);
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    op(16'h4123, 8'h00, 1'b0, "R1");
    op(16'hA010, 8'h00, 1'b0, "R1");

    // R2 bank writes incl. zero substitution and bit 7 ignored
    op(16'h2000, 8'h00, 1'b1, "R2");
    op(16'h5ABC, 8'h00, 1'b0, "R2");
    op(16'h3FFF, 8'hFF, 1'b1, "R2");
    op(16'h7FFF, 8'h00, 1'b0, "R2");
    op(16'h2100, 8'h80, 1'b1, "R2");
    op(16'h4000, 8'h00, 1'b0, "R2");
    op(16'h1234, 8'h00, 1'b0, "R2");

    // R3 enable by low nibble only, then R5 disabled RAM
    op(16'h0000, 8'h1A, 1'b1, "R3");
    op(16'hA001, 8'h00, 1'b0, "R3");
    op(16'h1FFF, 8'hAB, 1'b1, "R3");
    op(16'hA002, 8'h55, 1'b1, "R5");
    op(16'hA002, 8'h00, 1'b0, "R5");

    // R4 RAM bank 3 and 7
    op(16'h0000, 8'h0A, 1'b1, "R3");
    op(16'h4000, 8'h03, 1'b1, "R4");
    op(16'hB234, 8'h77, 1'b1, "R4");
    op(16'hB234, 8'h00, 1'b0, "R4");
    op(16'h5FFF, 8'h07, 1'b1, "R4");
    op(16'hBFFF, 8'h00, 1'b0, "R4");

    // R6/R7 clock window, back to back with the selector move
    op(16'h4000, 8'h0A, 1'b1, "R4");
    op(16'hA000, 8'h99, 1'b1, "R7");
    op(16'hA000, 8'h00, 1'b0, "R6");
    op(16'h4000, 8'h0C, 1'b1, "R4");
    op(16'hA100, 8'h42, 1'b1, "R7");
    op(16'hA100, 8'h00, 1'b0, "R6");

    // R8 absent clock and disabled clock
    present = 1'b0;
    op(16'hA100, 8'h00, 1'b0, "R8");
    op(16'hA100, 8'h13, 1'b1, "R8");
    present = 1'b1;
    op(16'h0000, 8'h00, 1'b1, "R3");
    op(16'hA100, 8'h24, 1'b1, "R8");
    op(16'hA100, 8'h00, 1'b0, "R8");
    op(16'h0000, 8'h0A, 1'b1, "R3");

    // R9 latch with and without clock
    op(16'h6000, 8'h01, 1'b1, "R9");
    present = 1'b0;
    op(16'h7FFF, 8'h00, 1'b1, "R9");
    present = 1'b1;
    op(16'h4000, 8'h00, 1'b0, "R9");

    // R10 unmapped selectors
    op(16'h4000, 8'h0D, 1'b1, "R10");
    op(16'hA000, 8'h00, 1'b0, "R10");
    op(16'hA000, 8'h11, 1'b1, "R10");
    op(16'h4000, 8'h88, 1'b1, "R10");
    op(16'hA000, 8'h00, 1'b0, "R10");
    op(16'h4000, 8'hFF, 1'b1, "R10");
    op(16'hA000, 8'h00, 1'b0, "R10");

    // R11 outside regions
    op(16'h8000, 8'h0A, 1'b1, "R11");
    op(16'hC123, 8'h03, 1'b1, "R11");
    op(16'hE000, 8'h00, 1'b0, "R11");
    op(16'h9FFF, 8'h00, 1'b0, "R11");
    op(16'h4000, 8'h00, 1'b0, "R11");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] rg;
      logic [15:0] a;
      logic [7:0] d;
      logic wr;
      case ($urandom_range(0, 11))
        0: rg = 3'd0;  1: rg = 3'd1;  2: rg = 3'd2;  3: rg = 3'd2;
        4: rg = 3'd3;  5: rg = 3'd4;  6: rg = 3'd6;  7: rg = 3'd7;
        default: rg = 3'd5;
      endcase
      a = {rg, 13'($urandom)};
      d = 8'($urandom);
      if (rg == 3'd2 && $urandom_range(0, 3) != 0) d = 8'($urandom_range(0, 14));
      if (rg == 3'd0 && $urandom_range(0, 1) == 0) d[3:0] = 4'hA;
      wr = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 19) == 0) present = ~present;
      op(a, d, wr, "");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule